// File: doc/BRIEF.md
# Privileged Trap Controller

This block holds the machine-level and supervisor-level trap state of a 32-bit RISC-V hart. That state covers the current privilege level, the status word, the trap vectors, the exception PCs, the cause and trap-value registers, the interrupt-enable and interrupt-pending sets, and the two delegation masks. It does not decode instructions. The pipeline tells it when a trap is needed by giving a cause, the faulting PC and a trap value. The controller then decides whether machine mode or supervisor mode handles the trap, saves the state, raises the privilege and returns the handler address in the same cycle.

The pipeline also signals the two return instructions with strobes. For each one the controller restores the saved privilege and the saved interrupt enable, and gives back the saved exception PC. At all times it reports the highest-priority interrupt that is both pending and enabled at the current privilege. The pipeline can turn that report into a trap request.

Software reaches the registers through a single-cycle CSR port. Reads are combinational. Writes take effect at the next clock edge. An access that the current privilege does not permit is flagged and has no effect.

Top module: `privTrapCtl`

## Requirements
- R1: At reset the privilege is machine (3). Every status, enable, pending, delegation, vector, exception-PC, cause and trap-value register reads 0.
- R2: A trap goes to supervisor mode (privilege 1) only when both of these hold: the current privilege is 0 or 1, and the delegation bit indexed by the cause code (cause bits 4:0) is set. An exception uses the exception delegation mask. An interrupt (cause bit 31 = 1) uses the interrupt delegation mask. Every other trap goes to machine mode (privilege 3).
- R3: A trap writes the cause, PC and value into the cause, exception-PC and trap-value registers of the target level. The enable bit at the index of the old privilege (bit 1 for S, bit 3 for M, 0 for U) is copied into the previous-enable bit: bit 5 for an S trap, bit 7 for an M trap. The old privilege goes to status bit 8 (S) or to bits 12:11 (M). The target's enable bit (bit 1 for S, bit 3 for M) is then cleared.
- R4: A machine return sets the privilege to status bits 12:11 and loads the enable bit at that index from bit 7. It then sets bit 7 to 1 and clears bits 12:11.
- R5: A supervisor return sets the privilege to status bit 8 and loads the enable bit at that index from bit 5. It then sets bit 5 to 1 and clears bit 8.
- R6: redirectValid is high in the same cycle as a trap or return request. redirectPc is the target's trap vector for a trap, the machine exception PC for a machine return, and the supervisor exception PC for a supervisor return.
- R7: A write to either trap vector clears bits 1:0 of the stored value. A write to either exception PC clears bit 0.
- R8: CSR addresses: status 0x300, supervisor status 0x100, enable 0x304, supervisor enable 0x104, pending 0x344, supervisor pending 0x144, interrupt delegation 0x303, exception delegation 0x302, vectors 0x305/0x105, exception PCs 0x341/0x141, causes 0x342/0x142, trap values 0x343/0x143. Any other address reads 0. Writable bits: enable 1,3,5,7,9; interrupt delegation 1,5,9; exception delegation 15:0; software pending 1,5; status 1,3,5,7,8,12:11,14:13; supervisor status 1,5,8,14:13. Reads of pending return the software bits ORed with hwPend.
- R9: Reads of supervisor enable and supervisor pending return the machine value ANDed with the interrupt delegation mask. Writes to them change only the bits set in that mask; for pending, only bits 1 and 5. Status bit 31 reads 1 when bits 14:13 are both 1.
- R10: The enabled set depends on the privilege. In M it is the non-delegated interrupts, and only when bit 3 is set. In S it is the non-delegated interrupts, plus the delegated ones when bit 1 is set. In U every interrupt is enabled. Among the interrupts that are pending, enabled in the enable register and in the enabled set, the lowest index wins. irqCause is 0x80000000 plus that index.
- R11: An access is flagged illegal when the privilege is below address bits 9:8, or when it is a write and address bits 11:10 are both 1. An illegal write changes nothing.
- R12: If a trap and a return come in the same cycle, the trap is taken. A machine return beats a supervisor return. A CSR write in the same cycle as a trap or a return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrEn | input | 1 | CSR access strobe |
| csrWe | input | 1 | Access is a write |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 32 | Write data |
| csrRdata | output | 32 | Combinational read data |
| csrIllegal | output | 1 | Access not permitted |
| trapReq | input | 1 | Take a trap this cycle |
| trapCause | input | 32 | Cause word, bit 31 set for interrupts |
| trapPc | input | 32 | PC of the trapping instruction |
| trapVal | input | 32 | Trap value |
| mretReq | input | 1 | Machine return strobe |
| sretReq | input | 1 | Supervisor return strobe |
| hwPend | input | 12 | Hardware interrupt-pending lines |
| irqValid | output | 1 | An enabled interrupt is pending |
| irqCause | output | 32 | Cause word of the selected interrupt |
| redirectValid | output | 1 | redirectPc is valid |
| redirectPc | output | 32 | Handler or return address |
| curPriv | output | 2 | Current privilege level |

## Verification
The bench drives traps from each privilege level with the delegation bit set and with it clear. A controller that ignored the current privilege would send a machine-mode trap to the supervisor handler. Returns are driven with the saved privilege field set to machine, supervisor and user. This catches restoring the wrong enable bit or leaving the saved field uncleared. Interrupts are raised in every mode, with delegated and non-delegated sources pending together, so a wrong priority order or a missing gate on the supervisor enable changes irqCause. Simultaneous trap, return and CSR-write requests expose a wrong priority. Writes that set every bit, illegal writes from user mode, and writes to the read-only address range expose leaky masks and unblocked writes.

// File: rtl/privTrapPkg.sv
package privTrapPkg;
  localparam int XLEN  = 32;
  localparam int IRQ_N = 12;
  localparam int EXC_N = 16;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // status bit positions; the return logic indexes enables by privilege
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;
  localparam int ST_FS   = 13;

  localparam logic [XLEN-1:0] STATUS_WMASK  = 32'h0000_79AA;
  localparam logic [XLEN-1:0] SSTATUS_MASK  = 32'h0000_6122;
  localparam logic [XLEN-1:0] IE_WMASK      = 32'h0000_02AA;
  localparam logic [XLEN-1:0] IDELEG_WMASK  = 32'h0000_0222;
  localparam logic [XLEN-1:0] IP_SWMASK     = 32'h0000_0022;

  localparam logic [11:0] A_MSTATUS = 12'h300;
  localparam logic [11:0] A_SSTATUS = 12'h100;
  localparam logic [11:0] A_MIE     = 12'h304;
  localparam logic [11:0] A_SIE     = 12'h104;
  localparam logic [11:0] A_MIP     = 12'h344;
  localparam logic [11:0] A_SIP     = 12'h144;
  localparam logic [11:0] A_IDELEG  = 12'h303;
  localparam logic [11:0] A_EDELEG  = 12'h302;
  localparam logic [11:0] A_MTVEC   = 12'h305;
  localparam logic [11:0] A_STVEC   = 12'h105;
  localparam logic [11:0] A_MEPC    = 12'h341;
  localparam logic [11:0] A_SEPC    = 12'h141;
  localparam logic [11:0] A_MCAUSE  = 12'h342;
  localparam logic [11:0] A_SCAUSE  = 12'h142;
  localparam logic [11:0] A_MTVAL   = 12'h343;
  localparam logic [11:0] A_STVAL   = 12'h143;

  typedef struct packed {
    logic takeTrap;
    logic toSuper;
    logic doMret;
    logic doSret;
    logic csrWrite;
  } ctlStrobe_t;
endpackage

// File: rtl/privTrapCtl_ctrl.sv
module privTrapCtl_ctrl
  import privTrapPkg::*;
#(
  parameter int IRQ_W = IRQ_N,
  parameter int EXC_W = EXC_N
) (
  input  logic [1:0]       privQ,
  input  logic             csrEn,
  input  logic             csrWe,
  input  logic [3:0]       csrAddrHi,
  input  logic             trapReq,
  input  logic             trapIsIrq,
  input  logic [4:0]       trapCode,
  input  logic             mretReq,
  input  logic             sretReq,
  input  logic             mieBit,
  input  logic             sieBit,
  input  logic [IRQ_W-1:0] idelegQ,
  input  logic [IRQ_W-1:0] ieQ,
  input  logic [IRQ_W-1:0] pendEff,
  input  logic [EXC_W-1:0] edelegQ,
  output ctlStrobe_t       stb,
  output logic             csrIllegal,
  output logic             irqValid,
  output logic [4:0]       irqIdx
);
  logic             delegHit;
  logic             anyEvent;
  logic [IRQ_W-1:0] enMask;
  logic [IRQ_W-1:0] sel;

  assign csrIllegal = csrEn && ((privQ < csrAddrHi[1:0]) || (csrWe && (&csrAddrHi[3:2])));

  always_comb begin
    delegHit = 1'b0;
    for (int i = 0; i < IRQ_W; i++)
      if (trapIsIrq && trapCode == 5'(i)) delegHit = idelegQ[i];
    for (int i = 0; i < EXC_W; i++)
      if (!trapIsIrq && trapCode == 5'(i)) delegHit = edelegQ[i];
  end

  assign anyEvent     = trapReq || mretReq || sretReq;
  assign stb.takeTrap = trapReq;
  assign stb.toSuper  = trapReq && (privQ <= PRIV_S) && delegHit;
  assign stb.doMret   = !trapReq && mretReq;
  assign stb.doSret   = !trapReq && !mretReq && sretReq;
  assign stb.csrWrite = csrEn && csrWe && !csrIllegal && !anyEvent;

  always_comb begin
    case (privQ)
      PRIV_M:  enMask = mieBit ? ~idelegQ : '0;
      PRIV_S:  enMask = ~idelegQ | (sieBit ? idelegQ : '0);
      default: enMask = '1;
    endcase
  end

  assign sel      = pendEff & ieQ & enMask;
  assign irqValid = |sel;

  always_comb begin
    irqIdx = '0;
    for (int i = IRQ_W - 1; i >= 0; i--)
      if (sel[i]) irqIdx = 5'(i);
  end
endmodule

// File: rtl/privTrapCtl_dp.sv
module privTrapCtl_dp
  import privTrapPkg::*;
#(
  parameter int IRQ_W = IRQ_N,
  parameter int EXC_W = EXC_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       stb,
  input  logic [11:0]      csrAddr,
  input  logic [XLEN-1:0]  csrWdata,
  input  logic [XLEN-1:0]  trapCause,
  input  logic [XLEN-1:0]  trapPc,
  input  logic [XLEN-1:0]  trapVal,
  input  logic [IRQ_W-1:0] hwPend,
  output logic [XLEN-1:0]  csrRdata,
  output logic [XLEN-1:0]  redirectPc,
  output logic [1:0]       privQ,
  output logic [XLEN-1:0]  statusQ,
  output logic [IRQ_W-1:0] ieQ,
  output logic [IRQ_W-1:0] idelegQ,
  output logic [EXC_W-1:0] edelegQ,
  output logic [IRQ_W-1:0] pendEff
);
  localparam logic [IRQ_W-1:0] IE_W  = IE_WMASK[IRQ_W-1:0];
  localparam logic [IRQ_W-1:0] ID_W  = IDELEG_WMASK[IRQ_W-1:0];
  localparam logic [IRQ_W-1:0] IP_W  = IP_SWMASK[IRQ_W-1:0];

  logic [IRQ_W-1:0] ipSwQ;
  logic [XLEN-1:0]  mtvecQ, stvecQ, mepcQ, sepcQ, mcauseQ, scauseQ, mtvalQ, stvalQ;
  logic [XLEN-1:0]  sdBit;
  logic             prevIe;
  logic [1:0]       mppQ;
  logic [IRQ_W-1:0] sipMask;

  assign pendEff = ipSwQ | hwPend;
  assign sdBit   = (&statusQ[ST_FS+1:ST_FS]) ? {1'b1, {(XLEN-1){1'b0}}} : '0;
  assign mppQ    = statusQ[ST_MPP+1:ST_MPP];
  assign sipMask = idelegQ & IP_W;

  always_comb begin
    case (privQ)
      PRIV_M:  prevIe = statusQ[ST_MIE];
      PRIV_S:  prevIe = statusQ[ST_SIE];
      default: prevIe = 1'b0;
    endcase
  end

  always_comb begin
    case (csrAddr)
      A_MSTATUS: csrRdata = statusQ | sdBit;
      A_SSTATUS: csrRdata = (statusQ & SSTATUS_MASK) | sdBit;
      A_MIE:     csrRdata = XLEN'(ieQ);
      A_SIE:     csrRdata = XLEN'(ieQ & idelegQ);
      A_MIP:     csrRdata = XLEN'(pendEff);
      A_SIP:     csrRdata = XLEN'(pendEff & idelegQ);
      A_IDELEG:  csrRdata = XLEN'(idelegQ);
      A_EDELEG:  csrRdata = XLEN'(edelegQ);
      A_MTVEC:   csrRdata = mtvecQ;
      A_STVEC:   csrRdata = stvecQ;
      A_MEPC:    csrRdata = mepcQ;
      A_SEPC:    csrRdata = sepcQ;
      A_MCAUSE:  csrRdata = mcauseQ;
      A_SCAUSE:  csrRdata = scauseQ;
      A_MTVAL:   csrRdata = mtvalQ;
      A_STVAL:   csrRdata = stvalQ;
      default:   csrRdata = '0;
    endcase
  end

  always_comb begin
    if (stb.takeTrap)    redirectPc = stb.toSuper ? stvecQ : mtvecQ;
    else if (stb.doMret) redirectPc = mepcQ;
    else if (stb.doSret) redirectPc = sepcQ;
    else                 redirectPc = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      privQ   <= PRIV_M;
      statusQ <= '0;
      ieQ     <= '0;
      ipSwQ   <= '0;
      idelegQ <= '0;
      edelegQ <= '0;
      mtvecQ  <= '0;
      stvecQ  <= '0;
      mepcQ   <= '0;
      sepcQ   <= '0;
      mcauseQ <= '0;
      scauseQ <= '0;
      mtvalQ  <= '0;
      stvalQ  <= '0;
    end else if (stb.takeTrap) begin
      if (stb.toSuper) begin
        scauseQ           <= trapCause;
        sepcQ             <= trapPc;
        stvalQ            <= trapVal;
        statusQ[ST_SPIE]  <= prevIe;
        statusQ[ST_SPP]   <= privQ[0];
        statusQ[ST_SIE]   <= 1'b0;
        privQ             <= PRIV_S;
      end else begin
        mcauseQ                   <= trapCause;
        mepcQ                     <= trapPc;
        mtvalQ                    <= trapVal;
        statusQ[ST_MPIE]          <= prevIe;
        statusQ[ST_MPP+1:ST_MPP]  <= privQ;
        statusQ[ST_MIE]           <= 1'b0;
        privQ                     <= PRIV_M;
      end
    end else if (stb.doMret) begin
      if (mppQ == PRIV_M) statusQ[ST_MIE] <= statusQ[ST_MPIE];
      if (mppQ == PRIV_S) statusQ[ST_SIE] <= statusQ[ST_MPIE];
      statusQ[ST_MPIE]         <= 1'b1;
      statusQ[ST_MPP+1:ST_MPP] <= PRIV_U;
      privQ                    <= mppQ;
    end else if (stb.doSret) begin
      if (statusQ[ST_SPP]) statusQ[ST_SIE] <= statusQ[ST_SPIE];
      statusQ[ST_SPIE] <= 1'b1;
      statusQ[ST_SPP]  <= 1'b0;
      privQ            <= {1'b0, statusQ[ST_SPP]};
    end else if (stb.csrWrite) begin
      case (csrAddr)
        A_MSTATUS: statusQ <= (statusQ & ~STATUS_WMASK) | (csrWdata & STATUS_WMASK);
        A_SSTATUS: statusQ <= (statusQ & ~SSTATUS_MASK) | (csrWdata & SSTATUS_MASK);
        A_MIE:     ieQ     <= (ieQ & ~IE_W) | (csrWdata[IRQ_W-1:0] & IE_W);
        A_SIE:     ieQ     <= (ieQ & ~idelegQ) | (csrWdata[IRQ_W-1:0] & idelegQ);
        A_MIP:     ipSwQ   <= (ipSwQ & ~IP_W) | (csrWdata[IRQ_W-1:0] & IP_W);
        A_SIP:     ipSwQ   <= (ipSwQ & ~sipMask) | (csrWdata[IRQ_W-1:0] & sipMask);
        A_IDELEG:  idelegQ <= csrWdata[IRQ_W-1:0] & ID_W;
        A_EDELEG:  edelegQ <= csrWdata[EXC_W-1:0];
        A_MTVEC:   mtvecQ  <= {csrWdata[XLEN-1:2], 2'b00};
        A_STVEC:   stvecQ  <= {csrWdata[XLEN-1:2], 2'b00};
        A_MEPC:    mepcQ   <= {csrWdata[XLEN-1:1], 1'b0};
        A_SEPC:    sepcQ   <= {csrWdata[XLEN-1:1], 1'b0};
        A_MCAUSE:  mcauseQ <= csrWdata;
        A_SCAUSE:  scauseQ <= csrWdata;
        A_MTVAL:   mtvalQ  <= csrWdata;
        A_STVAL:   stvalQ  <= csrWdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/privTrapCtl.sv
module privTrapCtl
  import privTrapPkg::*;
#(
  parameter int IRQ_W = IRQ_N,
  parameter int EXC_W = EXC_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrEn,
  input  logic             csrWe,
  input  logic [11:0]      csrAddr,
  input  logic [XLEN-1:0]  csrWdata,
  output logic [XLEN-1:0]  csrRdata,
  output logic             csrIllegal,
  input  logic             trapReq,
  input  logic [XLEN-1:0]  trapCause,
  input  logic [XLEN-1:0]  trapPc,
  input  logic [XLEN-1:0]  trapVal,
  input  logic             mretReq,
  input  logic             sretReq,
  input  logic [IRQ_W-1:0] hwPend,
  output logic             irqValid,
  output logic [XLEN-1:0]  irqCause,
  output logic             redirectValid,
  output logic [XLEN-1:0]  redirectPc,
  output logic [1:0]       curPriv
);
  ctlStrobe_t       stb;
  logic [1:0]       privQ;
  logic [XLEN-1:0]  statusQ;
  logic [IRQ_W-1:0] ieQ, idelegQ, pendEff;
  logic [EXC_W-1:0] edelegQ;
  logic [4:0]       irqIdx;

  privTrapCtl_ctrl #(.IRQ_W(IRQ_W), .EXC_W(EXC_W)) ctrl_i (
    .privQ(privQ), .csrEn(csrEn), .csrWe(csrWe), .csrAddrHi(csrAddr[11:8]),
    .trapReq(trapReq), .trapIsIrq(trapCause[XLEN-1]), .trapCode(trapCause[4:0]),
    .mretReq(mretReq), .sretReq(sretReq),
    .mieBit(statusQ[ST_MIE]), .sieBit(statusQ[ST_SIE]),
    .idelegQ(idelegQ), .ieQ(ieQ), .pendEff(pendEff), .edelegQ(edelegQ),
    .stb(stb), .csrIllegal(csrIllegal), .irqValid(irqValid), .irqIdx(irqIdx)
  );

  privTrapCtl_dp #(.IRQ_W(IRQ_W), .EXC_W(EXC_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .trapCause(trapCause), .trapPc(trapPc), .trapVal(trapVal), .hwPend(hwPend),
    .csrRdata(csrRdata), .redirectPc(redirectPc), .privQ(privQ), .statusQ(statusQ),
    .ieQ(ieQ), .idelegQ(idelegQ), .edelegQ(edelegQ), .pendEff(pendEff)
  );

  assign redirectValid = stb.takeTrap || stb.doMret || stb.doSret;
  assign irqCause      = irqValid ? {1'b1, {(XLEN-6){1'b0}}, irqIdx} : '0;
  assign curPriv       = privQ;
endmodule

// File: rtl/privTrapCtl_chk.sv
module privTrapCtl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        trapReq,
  input logic        mretReq,
  input logic        csrEn,
  input logic        csrWe,
  input logic        csrIllegal,
  input logic        irqValid,
  input logic        redirectValid,
  input logic [1:0]  redirectLo,
  input logic [1:0]  curPriv,
  input logic        mieBit,
  input logic        sieBit,
  input logic        mpieBit,
  input logic [1:0]  mppBits
);
  AST_TRAP_NO_DEMOTE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> ((curPriv == 2'd3) || (curPriv == 2'd1)) && (curPriv >= $past(curPriv))); // R2

  AST_TRAP_CLEARS_IE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> ((curPriv == 2'd3) ? !mieBit : !sieBit)); // R3

  AST_MRET_RESETS_MPP: assert property (@(posedge clk) disable iff (!rstN)
    (mretReq && !trapReq) |=> (mppBits == 2'd0) && mpieBit); // R4

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid && trapReq) |-> (redirectLo == 2'b00)); // R7

  AST_MIE_GATES_M: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && curPriv == 2'd3) |-> mieBit); // R10

  AST_M_READ_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (csrEn && !csrWe && curPriv == 2'd3) |-> !csrIllegal); // R11
endmodule

bind privTrapCtl privTrapCtl_chk chk_i (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .mretReq(mretReq),
  .csrEn(csrEn), .csrWe(csrWe), .csrIllegal(csrIllegal), .irqValid(irqValid),
  .redirectValid(redirectValid), .redirectLo(redirectPc[1:0]), .curPriv(curPriv),
  .mieBit(statusQ[3]), .sieBit(statusQ[1]), .mpieBit(statusQ[7]), .mppBits(statusQ[12:11])
);

// File: tb/privTrapCtl_tb_top.sv
module privTrapCtl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrEn = 0, csrWe = 0, trapReq = 0, mretReq = 0, sretReq = 0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0, trapCause = '0, trapPc = '0, trapVal = '0;
  logic [11:0] hwPend = '0;
  logic [31:0] csrRdata, irqCause, redirectPc;
  logic        csrIllegal, irqValid, redirectValid;
  logic [1:0]  curPriv;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state
  logic [31:0] rSt, rIe, rIp, rId, rEd, rMtv, rStv, rMep, rSep, rMca, rSca, rMtva, rStva;
  logic [1:0]  rPriv;

  always #(CLK_P/2) clk = ~clk;

  privTrapCtl dut_i (
    .clk(clk), .rstN(rstN), .csrEn(csrEn), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .csrIllegal(csrIllegal),
    .trapReq(trapReq), .trapCause(trapCause), .trapPc(trapPc), .trapVal(trapVal),
    .mretReq(mretReq), .sretReq(sretReq), .hwPend(hwPend), .irqValid(irqValid),
    .irqCause(irqCause), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .curPriv(curPriv)
  );

  task automatic modelReset();
    rSt = 0; rIe = 0; rIp = 0; rId = 0; rEd = 0; rMtv = 0; rStv = 0;
    rMep = 0; rSep = 0; rMca = 0; rSca = 0; rMtva = 0; rStva = 0; rPriv = 2'd3;
  endtask

  function automatic logic [31:0] pendAll();
    return rIp | {20'd0, hwPend};
  endfunction

  function automatic logic [31:0] expRead(logic [11:0] a);
    logic [31:0] sd;
    sd = (rSt[14:13] == 2'b11) ? 32'h8000_0000 : 32'h0;
    case (a)
      12'h300: return rSt | sd;
      12'h100: return (rSt & 32'h6122) | sd;
      12'h304: return rIe;
      12'h104: return rIe & rId;
      12'h344: return pendAll();
      12'h144: return pendAll() & rId;
      12'h303: return rId;
      12'h302: return rEd;
      12'h305: return rMtv;
      12'h105: return rStv;
      12'h341: return rMep;
      12'h141: return rSep;
      12'h342: return rMca;
      12'h142: return rSca;
      12'h343: return rMtva;
      12'h143: return rStva;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit expIllegal();
    if (!csrEn) return 0;
    return (int'(rPriv) < int'(csrAddr[9:8])) || (csrWe && csrAddr[11:10] == 2'b11);
  endfunction

  function automatic int expIrq();
    logic [31:0] en, cand;
    if (rPriv == 2'd3) en = rSt[3] ? ~rId : 32'h0;
    else if (rPriv == 2'd1) en = ~rId | (rSt[1] ? rId : 32'h0);
    else en = 32'hFFFF_FFFF;
    cand = pendAll() & rIe & en;
    for (int i = 0; i < 32; i++) if (cand[i]) return i;
    return -1;
  endfunction

  task automatic modelClock();
    bit toS, pie, ill;
    int code;
    logic [1:0] tgt;
    ill = expIllegal();
    code = int'(trapCause[4:0]);
    pie = (rPriv == 2'd3) ? rSt[3] : (rPriv == 2'd1) ? rSt[1] : 1'b0;
    if (trapReq) begin
      toS = 0;
      if (rPriv <= 2'd1) toS = trapCause[31] ? rId[code] : (code < 16 && rEd[code]);
      if (toS) begin
        rSca = trapCause; rSep = trapPc; rStva = trapVal;
        rSt[5] = pie; rSt[8] = rPriv[0]; rSt[1] = 0; rPriv = 2'd1;
      end else begin
        rMca = trapCause; rMep = trapPc; rMtva = trapVal;
        rSt[7] = pie; rSt[12:11] = rPriv; rSt[3] = 0; rPriv = 2'd3;
      end
    end else if (mretReq) begin
      tgt = rSt[12:11];
      if (tgt == 2'd3) rSt[3] = rSt[7];
      if (tgt == 2'd1) rSt[1] = rSt[7];
      rSt[7] = 1; rSt[12:11] = 0; rPriv = tgt;
    end else if (sretReq) begin
      tgt = {1'b0, rSt[8]};
      if (rSt[8]) rSt[1] = rSt[5];
      rSt[5] = 1; rSt[8] = 0; rPriv = tgt;
    end else if (csrEn && csrWe && !ill) begin
      case (csrAddr)
        12'h300: rSt = (rSt & ~32'h79AA) | (csrWdata & 32'h79AA);
        12'h100: rSt = (rSt & ~32'h6122) | (csrWdata & 32'h6122);
        12'h304: rIe = csrWdata & 32'h2AA;
        12'h104: rIe = (rIe & ~rId) | (csrWdata & rId);
        12'h344: rIp = csrWdata & 32'h22;
        12'h144: rIp = (rIp & ~(rId & 32'h22)) | (csrWdata & rId & 32'h22);
        12'h303: rId = csrWdata & 32'h222;
        12'h302: rEd = csrWdata & 32'hFFFF;
        12'h305: rMtv = csrWdata & ~32'h3;
        12'h105: rStv = csrWdata & ~32'h3;
        12'h341: rMep = csrWdata & ~32'h1;
        12'h141: rSep = csrWdata & ~32'h1;
        12'h342: rMca = csrWdata;
        12'h142: rSca = csrWdata;
        12'h343: rMtva = csrWdata;
        12'h143: rStva = csrWdata;
        default: ;
      endcase
    end
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    int irq;
    bit ill;
    logic [31:0] rpc;
    irq = expIrq();
    ill = expIllegal();
    chk(tag, "curPriv", {30'd0, curPriv}, {30'd0, rPriv});
    chk(tag, "irqValid", {31'd0, irqValid}, {31'd0, irq >= 0});
    if (irq >= 0) chk(tag, "irqCause", irqCause, 32'h8000_0000 | irq);
    chk(tag, "redirectValid", {31'd0, redirectValid}, {31'd0, trapReq | mretReq | sretReq});
    if (trapReq || mretReq || sretReq) begin
      if (trapReq) begin
        if (rPriv <= 2'd1 && (trapCause[31] ? rId[trapCause[4:0]]
                              : (trapCause[4:0] < 16 && rEd[trapCause[4:0]])))
          rpc = rStv;
        else
          rpc = rMtv;
      end else if (mretReq) rpc = rMep;
      else rpc = rSep;
      chk(tag, "redirectPc", redirectPc, rpc);
    end
    if (csrEn) begin
      chk(tag, "csrIllegal", {31'd0, csrIllegal}, {31'd0, ill});
      if (!ill && !csrWe) chk(tag, "csrRdata", csrRdata, expRead(csrAddr));
    end
  endtask

  task automatic step(string tag, bit en, bit we, logic [11:0] a, logic [31:0] wd,
                      bit tr, logic [31:0] cause, logic [31:0] pc, bit mr, bit sr);
    @(negedge clk);
    csrEn = en; csrWe = we; csrAddr = a; csrWdata = wd;
    trapReq = tr; trapCause = cause; trapPc = pc; trapVal = pc ^ 32'h5A5A_0000;
    mretReq = mr; sretReq = sr;
    #1;
    compareAll(tag);
    @(posedge clk);
    modelClock();
  endtask

  task automatic csrW(string tag, logic [11:0] a, logic [31:0] wd);
    step(tag, 1, 1, a, wd, 0, 0, 0, 0, 0);
  endtask
  task automatic csrR(string tag, logic [11:0] a);
    step(tag, 1, 0, a, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic trap(string tag, logic [31:0] cause, logic [31:0] pc);
    step(tag, 0, 0, 0, 0, 1, cause, pc, 0, 0);
  endtask
  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state
    #1 chk("R1", "curPriv", {30'd0, curPriv}, 32'd3);
    idle("R1");
    csrR("R1", 12'h300); csrR("R1", 12'h304); csrR("R1", 12'h344);
    csrR("R1", 12'h303); csrR("R1", 12'h302); csrR("R1", 12'h341);
    // R7: alignment on vector and exception-PC writes
    csrW("R7", 12'h305, 32'h0000_1003); csrR("R7", 12'h305);
    csrW("R7", 12'h105, 32'h0000_2002); csrR("R7", 12'h105);
    csrW("R7", 12'h341, 32'h0000_3001); csrR("R7", 12'h341);
    csrW("R7", 12'h141, 32'h0000_4003); csrR("R7", 12'h141);
    // R8: write masks
    csrW("R8", 12'h304, 32'hFFFF_FFFF); csrR("R8", 12'h304);
    csrW("R8", 12'h303, 32'hFFFF_FFFF); csrR("R8", 12'h303);
    csrW("R8", 12'h302, 32'hFFFF_FFFF); csrR("R8", 12'h302);
    csrW("R8", 12'h344, 32'hFFFF_FFFF); csrR("R8", 12'h344);
    csrW("R8", 12'h300, 32'hFFFF_FFFF);
    csrR("R8", 12'h7C0);
    // R9: supervisor views and the summary bit
    csrR("R9", 12'h300); csrR("R9", 12'h100); csrR("R9", 12'h104); csrR("R9", 12'h144);
    csrW("R9", 12'h104, 32'h0); csrR("R9", 12'h304);
    csrW("R9", 12'h304, 32'h2AA);
    // R10: interrupt selection in M
    idle("R10");
    hwPend = 12'h080; idle("R10");
    hwPend = 12'h088; idle("R10");
    csrR("R8", 12'h344);
    csrW("R10", 12'h300, 32'h0000_6000); idle("R10");
    hwPend = 12'h000;
    // R2, R3, R6: trap in M with the delegation bit set stays in M
    csrW("R3", 12'h300, 32'h0000_6008);
    trap("R6", 32'h2, 32'h0000_0100);
    csrR("R3", 12'h342); csrR("R3", 12'h341); csrR("R3", 12'h343); csrR("R3", 12'h300);
    // R4: machine return to user
    csrW("R4", 12'h300, 32'h0000_0080);
    step("R4", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R11: illegal accesses from U
    csrR("R11", 12'h300);
    csrW("R11", 12'h305, 32'h0000_5550);
    csrW("R11", 12'h105, 32'h0000_7770);
    // R10: everything enabled in U
    idle("R10");
    // R2: ecall from U delegated to S
    trap("R2", 32'h8, 32'h0000_0200);
    csrR("R3", 12'h142); csrR("R3", 12'h141); csrR("R3", 12'h143); csrR("R3", 12'h100);
    csrR("R11", 12'h342);
    csrR("R11", 12'h105);
    // R10 in S: delegated sources gated by bit 1
    idle("R10");
    hwPend = 12'h080; idle("R10");
    hwPend = 12'h000;
    csrW("R10", 12'h100, 32'h0000_0002); idle("R10");
    // R5: supervisor return to S, then to U
    csrW("R5", 12'h100, 32'h0000_0120);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    csrR("R5", 12'h100);
    csrW("R5", 12'h100, 32'h0000_0000);
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R2: interrupt delegation from U, then an undelegated interrupt from S
    trap("R2", 32'h8000_0005, 32'h0000_0300);
    csrR("R2", 12'h142);
    trap("R2", 32'h8000_0007, 32'h0000_0304);
    csrR("R3", 12'h342); csrR("R3", 12'h300); csrR("R3", 12'h343);
    // R12: priorities
    step("R12", 0, 0, 0, 0, 1, 32'h3, 32'h0000_0400, 1, 0);
    csrR("R12", 12'h342);
    csrW("R12", 12'h300, 32'h0000_1800);
    step("R12", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R12", 1, 1, 12'h305, 32'h0000_9990, 1, 32'h4, 32'h0000_0500, 0, 0);
    csrR("R12", 12'h305);
    csrR("R12", 12'h342);
    // R11: write to the read-only range in M
    csrW("R11", 12'hC00, 32'h1234_5678);
    csrR("R11", 12'h300);
    // R6: machine return after delegation cleared
    csrW("R6", 12'h302, 32'h0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    trap("R6", 32'h8, 32'h0000_0600);
    idle("R6");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule